// File: doc/BRIEF.md
# Redundant-Accumulator Booth Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and adds the product into a 40-bit accumulator. The accumulator is never resolved into plain binary inside the loop. It is kept as a pair of vectors, a sum and a carry, so every bit position carries a value of 0, 1 or 2. Each accepted operation recodes the multiplier into eight radix-4 Booth digits. Two layers of six-input column counters and one layer of full adders then fold the partial products and both stored vectors back into a new sum/carry pair. No register sits inside this path.

A block of operations ends when the number of accepted operations reaches the programmed tap limit. The redundant pair is then handed to a single two-operand adder, which costs one extra clock. At the same time the accumulator and the operation counter restart at zero for the next block. A typical user is an FIR filter that needs a binary result once per block of N taps.

Top module: `csa_booth_mac`

## Requirements
- R1: After reset, res_valid is 0, res_data is 0, the accumulator holds zero and the operation count is zero.
- R2: Each cycle with in_valid high and clr low adds the signed product op_a*op_b to the accumulated value, where the accumulated value is sum plus carry.
- R3: Products are exact over the full signed range of both operands, including -32768 times -32768, -32768 times 32767, -1 times -1 and a zero multiplier.
- R4: A cycle with in_valid low and clr low leaves the accumulator and the operation count unchanged. Idle cycles therefore do not count toward the block.
- R5: When an accepted operation brings the block count up to tap_limit, the binary total is produced. The total includes that operation. A tap_limit of 0 behaves like 1. The edge that accepts the operation is followed by one more edge, and after that edge res_data holds the total and res_valid is high for exactly one cycle, unless another conversion follows directly.
- R6: The operation that ends a block also restarts the accumulator and the count at zero. The next block's result contains none of the previous block.
- R7: clr high zeroes the sum, the carry and the count at the next edge. An operation presented in the same cycle is discarded.
- R8: The accumulated value wraps modulo 2^40.
- R9: res_data keeps its last converted value until the next conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the accumulator and the count; has priority over in_valid |
| in_valid | input | 1 | Accept op_a and op_b this cycle |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier, Booth-recoded |
| tap_limit | input | 16 | Operations per block; 0 is treated as 1 |
| res_data | output | 40 | Binary block total, modulo 2^40 |
| res_valid | output | 1 | One-cycle pulse when res_data is updated |

## Verification
The bench drives the extreme operand pairs in two ways. A design that mishandles the top Booth digit, or the negation correction bits, returns a wrong sign or loses a 2^30 term. Tests with back-to-back blocks and a mid-block clear would expose a design that failed to restart the accumulator or the count: its next total would carry leftover terms, or it would convert one operation too early or too late. Long runs of the largest positive product show whether the carry vector loses its top bits in a way that breaks the modulo-2^40 wrap. Idle gaps and the limit value 0 check that the count advances only on accepted operations and that a zero limit does not suppress conversion.

// File: rtl/csa_booth_mac.sv
module csa_booth_mac #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic [CNT_W-1:0] tap_limit,
  output logic [ACC_W-1:0] res_data,
  output logic             res_valid
);
  // reduction tree below is laid out for eight Booth digits (OP_W = 16)
  localparam int NDIG = OP_W / 2;

  typedef logic [ACC_W-1:0] vec_t;

  function automatic logic [ACC_W:0] booth_row(input logic [2:0] t, input vec_t ax);
    vec_t m;
    logic n;
    case (t)
      3'b001, 3'b010: begin m = ax;      n = 1'b0; end
      3'b011:         begin m = ax << 1; n = 1'b0; end
      3'b100:         begin m = ax << 1; n = 1'b1; end
      3'b101, 3'b110: begin m = ax;      n = 1'b1; end
      default:        begin m = '0;      n = 1'b0; end
    endcase
    return {n, n ? ~m : m};
  endfunction

  function automatic logic [2:0][ACC_W-1:0] cnt63(input vec_t x0, input vec_t x1, input vec_t x2,
                                                  input vec_t x3, input vec_t x4, input vec_t x5);
    logic [2:0] n;
    vec_t w0, w1, w2;
    for (int i = 0; i < ACC_W; i++) begin
      n = 3'(x0[i]) + 3'(x1[i]) + 3'(x2[i]) + 3'(x3[i]) + 3'(x4[i]) + 3'(x5[i]);
      w0[i] = n[0];
      w1[i] = n[1];
      w2[i] = n[2];
    end
    return {w2 << 2, w1 << 1, w0};
  endfunction

  vec_t acc_s, acc_c, conv_s, conv_c;
  logic [CNT_W-1:0] count;
  logic             conv_go;

  vec_t a_ext;
  logic [OP_W:0] bx;
  vec_t pp [NDIG];
  logic [NDIG-1:0] negbit;
  vec_t negv;

  assign a_ext = {{(ACC_W-OP_W){op_a[OP_W-1]}}, op_a};
  assign bx    = {op_b, 1'b0};

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [ACC_W:0] row;
    assign row       = booth_row(bx[2*g +: 3], a_ext);
    assign pp[g]     = row[ACC_W-1:0] << (2*g);
    assign negbit[g] = row[ACC_W];
  end

  always_comb begin
    negv = '0;
    for (int i = 0; i < NDIG; i++) negv[2*i] = negbit[i];
  end

  logic [2:0][ACC_W-1:0] lay_a, lay_b, lay_2;
  vec_t nxt_s, nxt_c;

  assign lay_a = cnt63(pp[0], pp[1], pp[2], pp[3], pp[4], pp[5]);
  assign lay_b = cnt63(pp[6], pp[7], negv, acc_s, acc_c, '0);
  assign lay_2 = cnt63(lay_a[0], lay_a[1], lay_a[2], lay_b[0], lay_b[1], lay_b[2]);
  assign nxt_s = lay_2[0] ^ lay_2[1] ^ lay_2[2];
  assign nxt_c = ((lay_2[0] & lay_2[1]) | (lay_2[0] & lay_2[2]) | (lay_2[1] & lay_2[2])) << 1;

  logic [CNT_W:0] cnt_inc;
  logic           last;
  assign cnt_inc = {1'b0, count} + 1'b1;
  assign last    = cnt_inc >= {1'b0, tap_limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_s     <= '0;
      acc_c     <= '0;
      count     <= '0;
      conv_s    <= '0;
      conv_c    <= '0;
      conv_go   <= 1'b0;
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      conv_go   <= 1'b0;
      res_valid <= conv_go;
      if (conv_go) res_data <= conv_s + conv_c;
      if (clr) begin
        acc_s <= '0;
        acc_c <= '0;
        count <= '0;
      end else if (in_valid) begin
        if (last) begin
          conv_s  <= nxt_s;
          conv_c  <= nxt_c;
          conv_go <= 1'b1;
          acc_s   <= '0;
          acc_c   <= '0;
          count   <= '0;
        end else begin
          acc_s <= nxt_s;
          acc_c <= nxt_c;
          count <= cnt_inc[CNT_W-1:0];
        end
      end
    end
  end

  // independent binary model of the accumulated value, used only by the checks
  logic signed [2*OP_W-1:0] prod;
  vec_t shadow;
  assign prod = $signed(op_a) * $signed(op_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 shadow <= '0;
    else if (clr)               shadow <= '0;
    else if (in_valid && last)  shadow <= '0;
    else if (in_valid)          shadow <= shadow + {{(ACC_W-2*OP_W){prod[2*OP_W-1]}}, prod};
  end

  p_sum_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_t'(acc_s + acc_c) == shadow);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> ($stable(acc_s) && $stable(acc_c) && $stable(count)));

  p_result_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(in_valid, 2) && !$past(clr, 2)));

  p_block_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr && last) |=> (count == '0 && acc_s == '0 && acc_c == '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_s == '0 && acc_c == '0 && count == '0));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_go) |-> $stable(res_data));
endmodule

// File: tb/sim_csa_booth_mac.sv
module sim_csa_booth_mac;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, clr, in_valid;
  logic [15:0] op_a, op_b, tap_limit;
  logic [39:0] res_data;
  logic        res_valid;

  csa_booth_mac u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .tap_limit(tap_limit),
    .res_data(res_data), .res_valid(res_valid)
  );

  int tests = 0;
  int fails = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp_v);
    tests++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp_v);
    end
  endtask

  function automatic logic [39:0] p40(input logic signed [15:0] a, input logic signed [15:0] b);
    longint p;
    p = longint'(a) * longint'(b);
    return p[39:0];
  endfunction

  function automatic logic [15:0] rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:16];
  endfunction

  task automatic send(input logic [15:0] a, input logic [15:0] b);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_result(input string tag, input logic [39:0] exp_v);
    @(negedge clk);
    chk({tag, " valid"}, 40'(res_valid), 40'd1);
    chk({tag, " data"}, res_data, exp_v);
    @(negedge clk);
    chk({tag, " pulse ends"}, 40'(res_valid), 40'd0);
  endtask

  task automatic t_reset();
    chk("R1 res_valid", 40'(res_valid), 40'd0);
    chk("R1 res_data", res_data, 40'd0);
  endtask

  task automatic t_booth();
    tap_limit = 16'd1;
    send(16'h8000, 16'h8000); expect_result("R3 min*min", 40'h00_4000_0000);
    send(16'h7FFF, 16'h8000); expect_result("R3 max*min", p40(16'sh7FFF, 16'sh8000));
    send(16'hFFFF, 16'hFFFF); expect_result("R3 -1*-1", 40'd1);
    send(16'd12345, 16'd0);   expect_result("R3 zero multiplier", 40'd0);
    send(16'd3, 16'hFFFB);    expect_result("R2 3*-5 with fresh accumulator R1", p40(16'sd3, -16'sd5));
  endtask

  task automatic t_blocks();
    tap_limit = 16'd5;
    for (int blk = 0; blk < 2; blk++) begin
      logic [39:0] e;
      e = '0;
      for (int k = 0; k < 5; k++) begin
        logic [15:0] a, b;
        a = rnd16(); b = rnd16();
        e = e + p40(a, b);
        send(a, b);
        if (k < 4) chk("R6 no early conversion", 40'(res_valid), 40'd0);
      end
      expect_result(blk == 0 ? "R2 block one" : "R6 independent block two", e);
    end
  endtask

  task automatic t_idle();
    tap_limit = 16'd3;
    send(16'd100, 16'hFF00);
    repeat (4) @(negedge clk);
    chk("R4 idle no result", 40'(res_valid), 40'd0);
    send(16'd7, 16'd9);
    repeat (2) @(negedge clk);
    send(16'hFFFE, 16'd11);
    expect_result("R4 idle cycles ignored", p40(16'sd100, -16'sd256) + p40(16'sd7, 16'sd9) + p40(-16'sd2, 16'sd11));
  endtask

  task automatic t_hold();
    repeat (6) @(negedge clk);
    chk("R9 data held", res_data, p40(16'sd100, -16'sd256) + p40(16'sd7, 16'sd9) + p40(-16'sd2, 16'sd11));
    chk("R9 valid low", 40'(res_valid), 40'd0);
  endtask

  task automatic t_clear();
    tap_limit = 16'd3;
    send(16'd100, 16'd100);
    send(16'd7, 16'd7);
    op_a = 16'd999; op_b = 16'd999; in_valid = 1'b1; clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
    chk("R7 no result from clear", 40'(res_valid), 40'd0);
    send(16'd2, 16'd3);
    send(16'd4, 16'd5);
    chk("R7 count restarted", 40'(res_valid), 40'd0);
    send(16'hFFFA, 16'd7);
    expect_result("R7 clear discards terms", p40(16'sd6, 16'sd1) + p40(16'sd20, 16'sd1) + p40(-16'sd6, 16'sd7));
  endtask

  task automatic t_limit0();
    tap_limit = 16'd0;
    send(16'hFFF9, 16'd9);
    expect_result("R5 limit zero acts as one", p40(-16'sd7, 16'sd9));
  endtask

  task automatic t_wrap();
    logic [39:0] e;
    e = '0;
    tap_limit = 16'd1101;
    for (int k = 0; k < 1100; k++) begin
      send(16'h8000, 16'h8000);
      e = e + 40'h00_4000_0000;
    end
    send(16'd1, 16'd1);
    e = e + 40'd1;
    expect_result("R8 wrap modulo 2^40", e);
    chk("R8 expected value", e, 40'd76 * 40'h00_4000_0000 + 40'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0;
    op_a = '0; op_b = '0; tap_limit = 16'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_booth();
    t_blocks();
    t_idle();
    t_hold();
    t_clear();
    t_limit0();
    t_wrap();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule